// File: doc/BRIEF.md
# Self-Checking Register Renamer

This block maps logical destination registers onto a pool of physical registers for an out-of-order core. It keeps a speculative map that rename consults and updates, an architectural map that only retirement updates, a circular queue of free physical registers, an in-order list of renamed destinations still in flight, and one ready bit and one free bit per physical register. Each cycle it can rename one destination, accept one writeback and retire the oldest in-flight destination, all at once.

On top of this bookkeeping the block checks its own consistency. At retirement, the mapping that a destination displaced when it was renamed has to match what the architectural map holds for that logical register. At writeback, the target physical register has to be allocated and not yet written. A broken rule sets a sticky fault bit, one bit for each kind of check. A corruption port overwrites one speculative map entry. It stands in for a transient upset, so the checks can be exercised from outside the block.

Top module: `reg_renamer`

## Requirements
- R1: After reset, logical register i maps to physical register i in both maps, the free queue holds physical registers NUM_LOG..NUM_PHYS-1 in ascending order, `renReady` is 1, `renPhys` shows NUM_LOG, `retReady` is 0 and `faultFlags` is 0.
- R2: A rename accepted while `renVld` and `renReady` are both high assigns the physical register at the head of the free queue, which `renPhys` shows in that cycle. From the next cycle the speculative map points that logical register to it. The mapping it displaced is recorded with the new in-flight entry.
- R3: The free queue is first-in first-out. The displaced physical register of each retired entry joins the tail, and rename reuses it only after every register that was ahead of it.
- R4: `renReady` is 0 when the free queue is empty or the in-flight list is full. A `renVld` pulse while `renReady` is 0 changes no state.
- R5: `retReady` is 1 exactly when the in-flight list is not empty. `retLog` and `retPhys` then show the oldest entry's logical register and the physical register assigned to it. `retVld` removes that entry. A `retVld` while the list is empty has no effect.
- R6: On retirement the architectural map entry for the logical register becomes the entry's new physical register. If the recorded displaced mapping differs from the architectural entry it replaces, `faultFlags` bit 0 is set.
- R7: A writeback (`wbVld`) to a physical register whose ready bit or free bit is set sets `faultFlags` bit 1 and leaves that ready bit unchanged. Otherwise the ready bit is set, so a second writeback to the same register faults.
- R8: Rename clears both the ready bit and the free bit of the assigned register. Retirement sets the free bit of the displaced register. Initially mapped registers start ready and not free, and queued registers start free.
- R9: The two `faultFlags` bits are independent and sticky. Only reset clears them.
- R10: Rename, writeback and retirement in the same cycle all take effect.
- R11: `injVld` overwrites the speculative map entry `injLog` with `injPhys` and touches nothing else. When a rename of the same logical register happens in the same cycle, the rename wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renVld | input | 1 | Rename request |
| renLog | input | 3 | Logical destination to rename |
| renReady | output | 1 | Rename can be accepted |
| renPhys | output | 4 | Physical register that the next rename receives |
| wbVld | input | 1 | Writeback strobe |
| wbPhys | input | 4 | Physical register written back |
| retVld | input | 1 | Retire the oldest in-flight entry |
| retReady | output | 1 | An in-flight entry exists |
| retLog | output | 3 | Logical register of the oldest entry |
| retPhys | output | 4 | Physical register assigned to the oldest entry |
| injVld | input | 1 | Corrupt a speculative map entry |
| injLog | input | 3 | Logical register whose entry is corrupted |
| injPhys | input | 4 | Value written into that entry |
| faultFlags | output | 2 | Bit 0: displaced-mapping mismatch; bit 1: bad writeback state |

## Verification
Renames of the same logical register issued back to back confirm that each displaced mapping is the previous in-flight register and not the initial identity mapping. Exhausting the free queue, then retiring one entry, shows that the returned register comes back at the tail. Writebacks are aimed at a queued register, at an initially ready register, at a fresh allocation written twice and at a register freed by retirement, which separates the ready-bit failure from the free-bit failure. A corrupted map entry is detected only at retirement, and a cycle that combines rename, writeback and retire shows that the three paths do not disturb each other.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic renFire;
    logic retFire;
    logic wbSet;
    logic injFire;
  } rn_strobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic flEmpty;
    logic alFull;
    logic alEmpty;
    logic retMismatch;
    logic wbBad;
  } rn_status_t;

  localparam int FAULT_PREV = 0;
  localparam int FAULT_WB   = 1;

endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       renVld,
  input  logic       wbVld,
  input  logic       retVld,
  input  logic       injVld,
  input  rn_status_t stat,
  output rn_strobe_t strb,
  output logic       renReady,
  output logic       retReady,
  output logic [1:0] faultFlags
);

  logic [1:0] faultNext;

  always_comb begin
    renReady     = !stat.flEmpty && !stat.alFull;
    retReady     = !stat.alEmpty;
    strb.renFire = renVld && renReady;
    strb.retFire = retVld && retReady;
    strb.wbSet   = wbVld && !stat.wbBad;
    strb.injFire = injVld;
    faultNext    = faultFlags;
    if (strb.retFire && stat.retMismatch) faultNext[FAULT_PREV] = 1'b1;
    if (wbVld && stat.wbBad)              faultNext[FAULT_WB]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) faultFlags <= '0;
    else       faultFlags <= faultNext;
  end

  // R9: flags never drop while out of reset
  assert_sticky_prev_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> !$fell(faultFlags[FAULT_PREV]));
  assert_sticky_wb_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> !$fell(faultFlags[FAULT_WB]));
  // R7: a writeback fault only follows a writeback
  assert_wb_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(faultFlags[FAULT_WB]) |-> $past(wbVld));
  // R6: a mapping fault only follows a retirement
  assert_prev_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(faultFlags[FAULT_PREV]) |-> $past(retVld));

endmodule

// File: rtl/rn_datapath.sv
module rn_datapath
  import rn_pkg::*;
#(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int AL_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rn_strobe_t                  strb,
  input  logic [$clog2(NUM_LOG)-1:0]  renLog,
  input  logic [$clog2(NUM_PHYS)-1:0] wbPhys,
  input  logic [$clog2(NUM_LOG)-1:0]  injLog,
  input  logic [$clog2(NUM_PHYS)-1:0] injPhys,
  output rn_status_t                  stat,
  output logic [$clog2(NUM_PHYS)-1:0] renPhys,
  output logic [$clog2(NUM_LOG)-1:0]  retLog,
  output logic [$clog2(NUM_PHYS)-1:0] retPhys
);

  localparam int LW    = $clog2(NUM_LOG);
  localparam int PW    = $clog2(NUM_PHYS);
  localparam int FAW   = $clog2(NUM_PHYS);
  localparam int FCW   = $clog2(NUM_PHYS + 1);
  localparam int AAW   = $clog2(AL_DEPTH);
  localparam int ACW   = $clog2(AL_DEPTH + 1);
  localparam int FREE0 = NUM_PHYS - NUM_LOG;

  // map tables
  logic [PW-1:0] specMap [NUM_LOG];
  logic [PW-1:0] archMap [NUM_LOG];

  // free queue
  logic [PW-1:0]  flMem [NUM_PHYS];
  logic [FAW-1:0] flHead, flTail;
  logic [FCW-1:0] flCount;

  // in-flight list
  logic [LW-1:0]  alLog [AL_DEPTH];
  logic [PW-1:0]  alNew [AL_DEPTH];
  logic [PW-1:0]  alOld [AL_DEPTH];
  logic [AAW-1:0] alHead, alTail;
  logic [ACW-1:0] alCount;

  // per-register state
  logic [NUM_PHYS-1:0] readyBits, freeBits, readyNext, freeNext;

  logic [PW-1:0] headOld;

  assign renPhys = flMem[flHead];
  assign retLog  = alLog[alHead];
  assign retPhys = alNew[alHead];
  assign headOld = alOld[alHead];

  always_comb begin
    stat.flEmpty     = (flCount == '0);
    stat.alFull      = (alCount == ACW'(AL_DEPTH));
    stat.alEmpty     = (alCount == '0);
    stat.retMismatch = (headOld != archMap[retLog]);
    stat.wbBad       = readyBits[wbPhys] || freeBits[wbPhys];
  end

  // per-register next-state, one slice per physical register
  for (genvar p = 0; p < NUM_PHYS; p++) begin : gBits
    always_comb begin
      readyNext[p] = readyBits[p];
      freeNext[p]  = freeBits[p];
      if (strb.wbSet && wbPhys == PW'(p))     readyNext[p] = 1'b1;
      if (strb.retFire && headOld == PW'(p))  freeNext[p]  = 1'b1;
      if (strb.renFire && renPhys == PW'(p)) begin
        readyNext[p] = 1'b0;
        freeNext[p]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        readyBits[i] <= (i < NUM_LOG);
        freeBits[i]  <= (i >= NUM_LOG);
      end
    end else begin
      readyBits <= readyNext;
      freeBits  <= freeNext;
    end
  end

  // maps
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        specMap[i] <= PW'(i);
        archMap[i] <= PW'(i);
      end
    end else begin
      if (strb.injFire) specMap[injLog] <= injPhys;
      if (strb.renFire) specMap[renLog] <= renPhys;
      if (strb.retFire) archMap[retLog] <= retPhys;
    end
  end

  // free queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PHYS; k++)
        flMem[k] <= (k < FREE0) ? PW'(NUM_LOG + k) : '0;
      flHead  <= '0;
      flTail  <= FAW'(FREE0 % NUM_PHYS);
      flCount <= FCW'(FREE0);
    end else begin
      if (strb.retFire) begin
        flMem[flTail] <= headOld;
        flTail <= (flTail == FAW'(NUM_PHYS - 1)) ? '0 : flTail + 1'b1;
      end
      if (strb.renFire)
        flHead <= (flHead == FAW'(NUM_PHYS - 1)) ? '0 : flHead + 1'b1;
      flCount <= flCount + FCW'(strb.retFire) - FCW'(strb.renFire);
    end
  end

  // in-flight list
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < AL_DEPTH; k++) begin
        alLog[k] <= '0;
        alNew[k] <= '0;
        alOld[k] <= '0;
      end
      alHead  <= '0;
      alTail  <= '0;
      alCount <= '0;
    end else begin
      if (strb.renFire) begin
        alLog[alTail] <= renLog;
        alNew[alTail] <= renPhys;
        alOld[alTail] <= specMap[renLog];
        alTail <= (alTail == AAW'(AL_DEPTH - 1)) ? '0 : alTail + 1'b1;
      end
      if (strb.retFire)
        alHead <= (alHead == AAW'(AL_DEPTH - 1)) ? '0 : alHead + 1'b1;
      alCount <= alCount + ACW'(strb.renFire) - ACW'(strb.retFire);
    end
  end

  // R3: registers queued plus registers in flight stay constant
  assert_pool_balance_R3: assert property (@(posedge clk) disable iff (!rstN)
    32'(flCount) + 32'(alCount) == 32'(FREE0));
  // R8: an allocated register is neither free nor ready afterwards
  assert_alloc_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.renFire |=> !freeBits[$past(renPhys)] && !readyBits[$past(renPhys)]);
  // R7: an accepted writeback leaves the register ready
  assert_wb_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wbSet && !(strb.renFire && renPhys == wbPhys) |=> readyBits[$past(wbPhys)]);
  // R6: retirement commits the new register into the architectural map
  assert_arch_update_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.retFire |=> archMap[$past(retLog)] == $past(retPhys));
  // R2: rename points the speculative map at the assigned register
  assert_spec_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.renFire |=> specMap[$past(renLog)] == $past(renPhys));

endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rn_pkg::*;
#(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int AL_DEPTH = 16,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renVld,
  input  logic [LW-1:0] renLog,
  output logic          renReady,
  output logic [PW-1:0] renPhys,
  input  logic          wbVld,
  input  logic [PW-1:0] wbPhys,
  input  logic          retVld,
  output logic          retReady,
  output logic [LW-1:0] retLog,
  output logic [PW-1:0] retPhys,
  input  logic          injVld,
  input  logic [LW-1:0] injLog,
  input  logic [PW-1:0] injPhys,
  output logic [1:0]    faultFlags
);

  rn_strobe_t strb;
  rn_status_t stat;

  rn_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .renVld(renVld), .wbVld(wbVld), .retVld(retVld), .injVld(injVld),
    .stat(stat), .strb(strb),
    .renReady(renReady), .retReady(retReady), .faultFlags(faultFlags)
  );

  rn_datapath #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .AL_DEPTH(AL_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .renLog(renLog), .wbPhys(wbPhys), .injLog(injLog), .injPhys(injPhys),
    .stat(stat), .renPhys(renPhys), .retLog(retLog), .retPhys(retPhys)
  );

endmodule

// File: tb/sim_reg_renamer.sv
module sim_reg_renamer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       renVld, wbVld, retVld, injVld;
  logic [2:0] renLog, injLog;
  logic [3:0] wbPhys, injPhys;
  logic       renReady, retReady;
  logic [3:0] renPhys, retPhys;
  logic [2:0] retLog;
  logic [1:0] faultFlags;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  reg_renamer u0 (
    .clk(clk), .rstN(rstN),
    .renVld(renVld), .renLog(renLog), .renReady(renReady), .renPhys(renPhys),
    .wbVld(wbVld), .wbPhys(wbPhys),
    .retVld(retVld), .retReady(retReady), .retLog(retLog), .retPhys(retPhys),
    .injVld(injVld), .injLog(injLog), .injPhys(injPhys),
    .faultFlags(faultFlags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    renVld = 0; wbVld = 0; retVld = 0; injVld = 0;
    renLog = 0; wbPhys = 0; injLog = 0; injPhys = 0;
  endtask

  // apply inputs for one cycle (inputs are set at a negedge by the caller)
  task automatic cycle();
    @(negedge clk);
    idleIn();
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    idleIn();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic ren(input int lg, input int expPhys, input string tag);
    renVld = 1; renLog = 3'(lg);
    #1;
    chk({tag, " renReady"}, renReady, 1);
    chk({tag, " renPhys"}, renPhys, expPhys);
    cycle();
  endtask

  task automatic ret(input int expLog, input int expPhys, input string tag);
    retVld = 1;
    #1;
    chk({tag, " retReady"}, retReady, 1);
    chk({tag, " retLog"}, retLog, expLog);
    chk({tag, " retPhys"}, retPhys, expPhys);
    cycle();
  endtask

  task automatic wb(input int p);
    wbVld = 1; wbPhys = 4'(p);
    cycle();
  endtask

  task automatic testReset();
    doReset();
    chk("R1 renReady", renReady, 1);
    chk("R1 renPhys", renPhys, 8);
    chk("R1 retReady", retReady, 0);
    chk("R1 faultFlags", faultFlags, 0);
  endtask

  task automatic testRenameRetire();
    doReset();
    ren(1, 8, "R2 a");
    ren(1, 9, "R2 b");
    ren(2, 10, "R2 c");
    ret(1, 8, "R5 a");
    ret(1, 9, "R5 b");
    ret(2, 10, "R5 c");
    chk("R5 empty", retReady, 0);
    retVld = 1; cycle();
    chk("R5 empty retire ignored", retReady, 0);
    chk("R6 no fault on clean retire", faultFlags, 0);
    for (int i = 0; i < 5; i++) ren(0, 11 + i, "R3 drain");
    // displaced registers return in retire order: 1, 8, 2
    ren(0, 1, "R3 reuse1");
    ren(0, 8, "R3 reuse8");
    ren(0, 2, "R3 reuse2");
    chk("R4 empty queue stalls", renReady, 0);
  endtask

  task automatic testStall();
    doReset();
    for (int i = 0; i < 8; i++) ren(i, 8 + i, "R2 fill");
    chk("R4 renReady low", renReady, 0);
    renVld = 1; renLog = 3'd5; cycle();
    chk("R4 ignored oldest log", retLog, 0);
    chk("R4 ignored oldest phys", retPhys, 8);
    ret(0, 8, "R5 pop");
    chk("R3 freed back", renReady, 1);
    chk("R3 freed reg is old map", renPhys, 0);
    ret(1, 9, "R4 no phantom entry");
  endtask

  task automatic testWriteback();
    doReset();
    wb(8);
    chk("R7 wb to free reg", faultFlags, 2);
    doReset();
    chk("R9 reset clears", faultFlags, 0);
    wb(3);
    chk("R7 wb to ready reg", faultFlags, 2);
    doReset();
    ren(4, 8, "R8 alloc");
    wb(8);
    chk("R8 allocated reg accepts wb", faultFlags, 0);
    wb(8);
    chk("R7 second wb faults", faultFlags, 2);
    doReset();
    ren(1, 8, "R8 alloc2");
    wb(8);
    ret(1, 8, "R8 retire");
    wb(1);
    chk("R8 retired old is free", faultFlags, 2);
  endtask

  task automatic testCorrupt();
    doReset();
    injVld = 1; injLog = 3'd2; injPhys = 4'd12; cycle();
    chk("R11 queue untouched", renPhys, 8);
    ren(2, 8, "R11 rename");
    chk("R6 no fault before retire", faultFlags, 0);
    ret(2, 8, "R6 retire");
    chk("R6 mismatch flagged", faultFlags, 1);
    wb(8);
    chk("R9 independent bits", faultFlags, 1);
    wb(8);
    chk("R9 both bits", faultFlags, 3);
    for (int i = 0; i < 3; i++) cycle();
    chk("R9 sticky", faultFlags, 3);
  endtask

  task automatic testSameCycle();
    doReset();
    ren(3, 8, "R10 first");
    renVld = 1; renLog = 3'd4; wbVld = 1; wbPhys = 4'd8; retVld = 1;
    #1;
    chk("R10 renPhys", renPhys, 9);
    chk("R10 retPhys", retPhys, 8);
    cycle();
    chk("R10 no fault", faultFlags, 0);
    chk("R10 oldest log", retLog, 4);
    chk("R10 oldest phys", retPhys, 9);
    chk("R10 next head", renPhys, 10);
    wb(8);
    chk("R10 ready was set", faultFlags, 2);
  endtask

  initial begin
    idleIn();
    rstN = 0;
    testReset();
    testRenameRetire();
    testStall();
    testWriteback();
    testCorrupt();
    testSameCycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog R1..: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule